// File: doc/BRIEF.md
# Quarter-Pel Separable Luma Interpolator

This block builds one 8x8 block of motion-compensated luma samples from an 8-bit reference window that holds 11 rows by 11 columns. The window starts one row above the block and one column to its left, and reaches two rows below and two columns to the right. A horizontal fraction and a vertical fraction, each 0 to 3 quarter-pel steps, choose a 4-tap filter for each direction. When both fractions are nonzero, a vertical pass produces signed 16-bit intermediates and a horizontal pass finishes them. Each pass uses its own rounding constant and shift. When only one fraction is nonzero, a single rounded pass is applied. When both are zero, the block copies the source pixels.

A pulse on `start` latches the fractions, the rounding bit and the put/average choice. The window then streams in one row per beat on a valid/ready channel: `in_ready` is high only while window rows are being collected, and a beat is accepted on any edge where `in_valid` and `in_ready` are both high. Results leave one 8-byte row per beat on a second valid/ready channel. While `out_valid` is high and `out_ready` is low, the row is held. In average mode every result row is joined with one prior destination row from a third channel: `out_valid` rises only while `old_valid` is high, and `old_ready` is high together with `out_ready`, so both channels complete on the same edge. `done` pulses for one cycle after the last row has been accepted.

Top module: `qpel_interp`

## Requirements
- R1: The fractions, the rounding bit and the average select are sampled only on a `start` pulse while the block is idle; changes to those inputs during a block have no effect on that block's output.
- R2: After `start`, exactly 11 window rows are accepted. In each row, byte k (bits 8k+7..8k) is window column k, and column 0 lies one pixel left of the block. `in_ready` is low out of reset, low while idle and low once the 11th row has been taken.
- R3: Eight result rows leave in order from top to bottom. Byte j of `out_row` is block column j. A row that is offered but not accepted stays unchanged, and `done` is high for exactly the one cycle after the 8th row is accepted.
- R4: With both fractions 0, output pixel (r, c) equals window pixel (r+1, c+1).
- R5: For samples p(-1), p(0), p(1), p(2) around the output position, fraction 1 applies taps -4, 53, 18, -3, fraction 2 applies -1, 9, 9, -1 and fraction 3 applies -3, 18, 53, -4.
- R6: With only the horizontal fraction nonzero, fraction 2 gives (sum + 8 - rnd) >> 4 and fractions 1 and 3 give (sum + 32 - rnd) >> 6.
- R7: With only the vertical fraction nonzero, the same rounding applies as in R6, with rnd replaced by 1 - rnd.
- R8: With both fractions nonzero, the vertical pass uses shift s = (w(h) + w(v)) >> 1, where w = 1 for fraction 2 and 5 otherwise. It adds 2^(s-1) + rnd - 1 and shifts right arithmetically, giving one signed intermediate for each of the 11 window columns.
- R9: The horizontal pass over these intermediates gives (sum + 64 - rnd) >> 7, using an arithmetic shift.
- R10: Every filtered pixel is clamped to 0..255 before output.
- R11: In average mode, each output byte is (f + d + 1) >> 1, where f is the filtered pixel and d is the matching byte of `old_row`. An output row is transferred only on an edge where `old_valid`, `out_valid` and `out_ready` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a block when idle; latches the mode inputs |
| hmode_i | input | 2 | Horizontal fraction in quarter pels |
| vmode_i | input | 2 | Vertical fraction in quarter pels |
| rnd_i | input | 1 | Rounding-control bit |
| avg_i | input | 1 | 1 = average with prior destination, 0 = put |
| in_valid | input | 1 | Window row available |
| in_ready | output | 1 | Block accepts a window row |
| in_row | input | 88 | Window row, 11 bytes, column 0 in the low byte |
| old_valid | input | 1 | Prior destination row available (average mode) |
| old_ready | output | 1 | Prior destination row consumed this edge |
| old_row | input | 64 | Prior destination row, 8 bytes |
| out_valid | output | 1 | Result row available |
| out_ready | input | 1 | Consumer accepts the result row |
| out_row | output | 64 | Result row, 8 bytes, column 0 in the low byte |
| done | output | 1 | One-cycle pulse after the last row is accepted |

## Verification
A window row stored in the wrong slot, or a row pointer that is off by one, shifts the vertical support. It corrupts the very first emitted row of any block with a vertical fraction, or of a copy. A wrong intermediate shift or bias appears only in two-pass blocks, but it does so in every row, so one such block exposes it within its eight output beats. Errors in the handshake show up as a changed row under back-pressure, as an extra or missing row, or as `done` appearing on the wrong cycle. All of these are visible within one block.

// File: rtl/qpel_pkg.sv
package qpel_pkg;
  localparam int PIX_W = 8;
  localparam int INT_W = 16;
  localparam int ACC_W = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_VERT, ST_EMIT} qpel_state_e;

  function automatic logic [PIX_W-1:0] sat_pix(input logic signed [ACC_W-1:0] v);
    if (v < 0)        return '0;
    else if (v > 255) return 8'hFF;
    else              return v[PIX_W-1:0];
  endfunction

  // Rounding for a filter applied in one direction only.
  function automatic logic [PIX_W-1:0] round_single(input logic signed [ACC_W-1:0] s,
                                                     input logic [1:0] mode,
                                                     input logic rc);
    logic signed [ACC_W-1:0] b;
    logic signed [ACC_W-1:0] t;
    b = (mode == 2'd2) ? ACC_W'(8) : ACC_W'(32);
    b = b - {{(ACC_W-1){1'b0}}, rc};
    t = s + b;
    t = (mode == 2'd2) ? (t >>> 4) : (t >>> 6);
    return sat_pix(t);
  endfunction

  // Shift used by the first pass when both fractions are nonzero.
  function automatic logic [2:0] pass1_shift(input logic [1:0] hm, input logic [1:0] vm);
    logic [3:0] wh;
    logic [3:0] wv;
    logic [3:0] sum;
    wh  = (hm == 2'd2) ? 4'd1 : 4'd5;
    wv  = (vm == 2'd2) ? 4'd1 : 4'd5;
    sum = wh + wv;
    return sum[3:1];
  endfunction
endpackage

// File: rtl/qpel_tap4.sv
module qpel_tap4 #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  s0,
  input  logic signed [IN_W-1:0]  s1,
  input  logic signed [IN_W-1:0]  s2,
  input  logic signed [IN_W-1:0]  s3,
  input  logic        [1:0]       mode,
  output logic signed [OUT_W-1:0] acc
);
  localparam logic signed [OUT_W-1:0] K3  = OUT_W'(3);
  localparam logic signed [OUT_W-1:0] K4  = OUT_W'(4);
  localparam logic signed [OUT_W-1:0] K9  = OUT_W'(9);
  localparam logic signed [OUT_W-1:0] K18 = OUT_W'(18);
  localparam logic signed [OUT_W-1:0] K53 = OUT_W'(53);

  logic signed [OUT_W-1:0] e0, e1, e2, e3;

  always_comb begin
    e0 = OUT_W'(s0);
    e1 = OUT_W'(s1);
    e2 = OUT_W'(s2);
    e3 = OUT_W'(s3);
    case (mode)
      2'd1:    acc = e1 * K53 + e2 * K18 - e0 * K4 - e3 * K3;
      2'd2:    acc = (e1 + e2) * K9 - e0 - e3;
      2'd3:    acc = e2 * K53 + e1 * K18 - e3 * K4 - e0 * K3;
      default: acc = e1;
    endcase
  end
endmodule

// File: rtl/qpel_window.sv
module qpel_window #(
  parameter int ROWS = 11,
  parameter int COLS = 11,
  parameter int PW   = 8,
  parameter int TAPN = 4
) (
  input  logic                                  clk,
  input  logic                                  wr_en,
  input  logic [$clog2(ROWS)-1:0]               wr_idx,
  input  logic [COLS*PW-1:0]                    wr_data,
  input  logic [$clog2(ROWS)-1:0]               rd_base,
  output logic [TAPN-1:0][COLS*PW-1:0]          rd_rows
);
  localparam int RW    = $clog2(ROWS);
  localparam int ROW_W = COLS * PW;

  logic [ROW_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar k = 0; k < TAPN; k++) begin : g_rd
    logic [RW-1:0] idx;
    assign idx        = rd_base + RW'(k);
    assign rd_rows[k] = mem[idx];
  end
endmodule

// File: rtl/qpel_interp.sv
module qpel_interp
  import qpel_pkg::*;
#(
  parameter int BLK = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           hmode_i,
  input  logic [1:0]           vmode_i,
  input  logic                 rnd_i,
  input  logic                 avg_i,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [(BLK+3)*8-1:0] in_row,
  input  logic                 old_valid,
  output logic                 old_ready,
  input  logic [BLK*8-1:0]     old_row,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [BLK*8-1:0]     out_row,
  output logic                 done
);
  localparam int TAPN  = 4;
  localparam int WIN   = BLK + TAPN - 1;
  localparam int ROW_W = WIN * PIX_W;
  localparam int RW    = $clog2(WIN);

  qpel_state_e state;
  logic [1:0]  hm, vm;
  logic        rb, av;
  logic [RW-1:0] ld_cnt, row;
  logic [WIN-1:0][INT_W-1:0] inter_q, inter_d;
  logic [TAPN-1:0][ROW_W-1:0] taps;
  logic out_fire;

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_EMIT) && (!av || old_valid);
  assign old_ready = (state == ST_EMIT) && av && out_ready;
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hm     <= '0;
      vm     <= '0;
      rb     <= 1'b0;
      av     <= 1'b0;
      ld_cnt <= '0;
      row    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          hm     <= hmode_i;
          vm     <= vmode_i;
          rb     <= rnd_i;
          av     <= avg_i;
          ld_cnt <= '0;
          state  <= ST_LOAD;
        end
        ST_LOAD: if (in_valid) begin
          ld_cnt <= ld_cnt + 1'b1;
          if (ld_cnt == RW'(WIN-1)) begin
            row   <= '0;
            state <= ST_VERT;
          end
        end
        ST_VERT: state <= ST_EMIT;
        default: if (out_fire) begin
          if (row == RW'(BLK-1)) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            row   <= row + 1'b1;
            state <= ST_VERT;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  inter_q <= '0;
    else if (state == ST_VERT)   inter_q <= inter_d;
  end

  qpel_window #(.ROWS(WIN), .COLS(WIN), .PW(PIX_W), .TAPN(TAPN)) i_window (
    .clk     (clk),
    .wr_en   (in_valid && in_ready),
    .wr_idx  (ld_cnt),
    .wr_data (in_row),
    .rd_base (row),
    .rd_rows (taps)
  );

  // First pass: one vertical filter per window column.
  logic [2:0] vsh;
  logic signed [ACC_W-1:0] vbias;
  always_comb begin
    vsh   = pass1_shift(hm, vm);
    vbias = ACC_W'(1) << (vsh - 3'd1);
    if (!rb) vbias = vbias - ACC_W'(1);
  end

  for (genvar c = 0; c < WIN; c++) begin : g_vert
    logic signed [INT_W-1:0] px [TAPN];
    logic signed [ACC_W-1:0] vsum, vt;
    logic [INT_W-1:0] col;
    for (genvar k = 0; k < TAPN; k++) begin : g_px
      assign px[k] = INT_W'(taps[k][c*PIX_W +: PIX_W]);
    end
    qpel_tap4 #(.IN_W(INT_W), .OUT_W(ACC_W)) i_vtap (
      .s0(px[0]), .s1(px[1]), .s2(px[2]), .s3(px[3]), .mode(vm), .acc(vsum)
    );
    always_comb begin
      vt = (vsum + vbias) >>> vsh;
      if (vm == 2'd0)      col = INT_W'(taps[1][c*PIX_W +: PIX_W]);
      else if (hm != 2'd0) col = vt[INT_W-1:0];
      else                 col = INT_W'(round_single(vsum, vm, ~rb));
    end
    assign inter_d[c] = col;
  end

  // Second pass: horizontal filter over the registered row.
  logic signed [ACC_W-1:0] hbias;
  assign hbias = rb ? ACC_W'(63) : ACC_W'(64);

  for (genvar j = 0; j < BLK; j++) begin : g_hor
    logic signed [ACC_W-1:0] hsum, ht;
    logic [PIX_W-1:0] pix;
    logic [PIX_W:0]   mix;
    qpel_tap4 #(.IN_W(INT_W), .OUT_W(ACC_W)) i_htap (
      .s0(inter_q[j]), .s1(inter_q[j+1]), .s2(inter_q[j+2]), .s3(inter_q[j+3]),
      .mode(hm), .acc(hsum)
    );
    always_comb begin
      ht = (hsum + hbias) >>> 7;
      if (hm == 2'd0)      pix = inter_q[j+1][PIX_W-1:0];
      else if (vm == 2'd0) pix = round_single(hsum, hm, rb);
      else                 pix = sat_pix(ht);
      mix = {1'b0, pix} + {1'b0, old_row[j*PIX_W +: PIX_W]} + 9'd1;
    end
    assign out_row[j*PIX_W +: PIX_W] = av ? mix[PIX_W:1] : pix;
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable({hm, vm, rb, av})); // R1
  AST_LOAD_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ld_cnt == RW'(WIN-1)) |=> !in_ready); // R2
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !av) |=> (out_valid && $stable(out_row))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_AVG_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && av) |-> (old_valid && old_ready)); // R11
endmodule

// File: tb/test_qpel_interp.sv
module test_qpel_interp;
  localparam int BLK = 8;
  localparam int WIN = BLK + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] hmode_i = '0, vmode_i = '0;
  logic rnd_i = 1'b0, avg_i = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [WIN*8-1:0] in_row = '0;
  logic old_valid = 1'b0, old_ready;
  logic [BLK*8-1:0] old_row = '0;
  logic out_valid, out_ready = 1'b0;
  logic [BLK*8-1:0] out_row;
  logic done;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int win_m [WIN][WIN];
  int old_m [BLK][BLK];

  always #2 clk = ~clk;

  qpel_interp #(.BLK(BLK)) i_qpel_interp (
    .clk(clk), .rst_n(rst_n), .start(start), .hmode_i(hmode_i), .vmode_i(vmode_i),
    .rnd_i(rnd_i), .avg_i(avg_i), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .old_valid(old_valid), .old_ready(old_ready), .old_row(old_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual %0d cycles, expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int tap(int m, int k);
    int t1[4] = '{-4, 53, 18, -3};
    int t2[4] = '{-1, 9, 9, -1};
    if (m == 1) return t1[k];
    if (m == 2) return t2[k];
    return t1[3-k];
  endfunction

  function automatic int clip(int x);
    return (x < 0) ? 0 : ((x > 255) ? 255 : x);
  endfunction

  function automatic int one_pass(int s, int m, int rc);
    if (m == 2) return clip((s + 8 - rc) >>> 4);
    return clip((s + 32 - rc) >>> 6);
  endfunction

  function automatic int exp_pix(int r, int c, int h, int v, int rb, int a);
    int p, s, sv, ik;
    if (h == 0 && v == 0) p = win_m[r+1][c+1];
    else if (v == 0) begin
      s = 0;
      for (int k = 0; k < 4; k++) s += tap(h, k) * win_m[r+1][c+k];
      p = one_pass(s, h, rb);
    end else if (h == 0) begin
      s = 0;
      for (int k = 0; k < 4; k++) s += tap(v, k) * win_m[r+k][c+1];
      p = one_pass(s, v, 1 - rb);
    end else begin
      sv = (((h == 2) ? 1 : 5) + ((v == 2) ? 1 : 5)) >> 1;
      s = 0;
      for (int k = 0; k < 4; k++) begin
        ik = 0;
        for (int q = 0; q < 4; q++) ik += tap(v, q) * win_m[r+q][c+k];
        ik = (ik + (1 << (sv - 1)) + rb - 1) >>> sv;
        s += tap(h, k) * ik;
      end
      p = clip((s + 64 - rb) >>> 7);
    end
    if (a != 0) p = (p + old_m[r][c] + 1) >> 1;
    return p;
  endfunction

  function automatic logic [63:0] exp_row(int r, int h, int v, int rb, int a);
    logic [63:0] w = '0;
    for (int j = 0; j < BLK; j++) w[j*8 +: 8] = 8'(exp_pix(r, j, h, v, rb, a));
    return w;
  endfunction

  task automatic fill(int kind);
    for (int r = 0; r < WIN; r++)
      for (int c = 0; c < WIN; c++)
        case (kind)
          1: win_m[r][c] = (r * 23 + c * 7) % 256;
          2: win_m[r][c] = ((r + c) % 2 == 1) ? 255 : 0;
          3: win_m[r][c] = (c % 2 == 1) ? 255 : 0;
          default: win_m[r][c] = int'($urandom % 256);
        endcase
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) old_m[r][c] = int'($urandom % 256);
  endtask

  task automatic run_block(string tag, int h, int v, int rb, int a, bit stress);
    logic [63:0] held_val;
    bit held, fire, acc;
    @(negedge clk);
    hmode_i = 2'(h); vmode_i = 2'(v); rnd_i = 1'(rb); avg_i = 1'(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: scramble the mode inputs once the block has started
    hmode_i = 2'($urandom); vmode_i = 2'($urandom); rnd_i = 1'($urandom); avg_i = 1'($urandom);
    for (int i = 0; i < WIN; i++) begin
      if (stress && ($urandom % 3 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      acc = 1'b0;
      while (!acc) begin
        in_valid = 1'b1;
        for (int c = 0; c < WIN; c++) in_row[c*8 +: 8] = 8'(win_m[i][c]);
        #1;
        acc = in_ready;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    #1;
    chk("R2", {63'd0, in_ready}, 64'd0);
    for (int r = 0; r < BLK; r++) begin
      held = 1'b0;
      fire = 1'b0;
      old_valid = 1'b0;
      for (int j = 0; j < BLK; j++) old_row[j*8 +: 8] = 8'(old_m[r][j]);
      while (!fire) begin
        out_ready = stress ? 1'($urandom) : 1'b1;
        if (!old_valid) old_valid = stress ? 1'($urandom) : 1'b1;
        #1;
        if (held) chk("R3", {63'd0, out_valid}, 64'd1);
        if (held && out_valid) chk("R3", out_row, held_val);
        fire = out_valid && out_ready && (a == 0 || old_valid);
        if (fire) chk(tag, out_row, exp_row(r, h, v, rb, a));
        held = out_valid && !out_ready && (a == 0);
        held_val = out_row;
        @(negedge clk);
      end
    end
    out_ready = 1'b0;
    old_valid = 1'b0;
    #1;
    chk("R3", {63'd0, done}, 64'd1);
    @(negedge clk);
    #1;
    chk("R3", {63'd0, done}, 64'd0);
  endtask

  function automatic string tag_for(int h, int v, int a);
    if (a != 0) return "R11";
    if (h == 0 && v == 0) return "R4";
    if (v == 0) return "R6";
    if (h == 0) return "R7";
    return "R9";
  endfunction

  initial begin
    int h, v, rb, a, kind;
    void'($urandom(32'd1234));
    #1;
    chk("R2", {63'd0, in_ready}, 64'd0);
    chk("R3", {62'd0, out_valid, done}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R2", {63'd0, in_ready}, 64'd0);

    fill(1); run_block("R4", 0, 0, 0, 0, 0);
    for (int m = 1; m < 4; m++) begin
      fill(0); run_block("R5", m, 0, 0, 0, 0);
      fill(0); run_block("R5", 0, m, 1, 0, 0);
      fill(1); run_block("R6", m, 0, 1, 0, 1);
      fill(1); run_block("R7", 0, m, 0, 0, 1);
    end
    fill(0); run_block("R8", 1, 1, 0, 0, 0);
    fill(0); run_block("R8", 2, 2, 1, 0, 0);
    fill(1); run_block("R8", 1, 2, 1, 0, 0);
    fill(0); run_block("R9", 3, 2, 0, 0, 1);
    fill(0); run_block("R9", 3, 3, 1, 0, 0);
    fill(2); run_block("R10", 1, 0, 0, 0, 0);
    fill(3); run_block("R10", 2, 0, 1, 0, 0);
    fill(2); run_block("R10", 0, 3, 0, 0, 0);
    fill(2); run_block("R10", 1, 3, 0, 0, 0);
    fill(3); run_block("R10", 3, 1, 1, 0, 1);
    fill(0); run_block("R11", 1, 2, 0, 1, 0);
    fill(1); run_block("R11", 0, 0, 1, 1, 1);
    fill(0); run_block("R1", 2, 1, 1, 0, 1);
    for (int t = 0; t < 24; t++) begin
      h = int'($urandom % 4); v = int'($urandom % 4);
      rb = int'($urandom % 2); a = int'($urandom % 2);
      kind = int'($urandom % 4);
      fill(kind);
      run_block(tag_for(h, v, a), h, v, rb, a, 1);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule